// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block sits next to a simple processor core and decides when the core leaves its instruction stream for a service routine and when it comes back. It collects three kinds of cause: fault signals, software trap (system call) requests and external interrupt requests. Each cause has its own slot in one shared, programmable vector table. When a cause is taken, the block saves the return address and the current privilege mode. It then forces the core into monitor mode and blocks further entries until the routine returns. Finally it emits a one-cycle redirect carrying the routine's address.

A return request sends the core back to the saved address in the saved mode, and lets the next pending cause in. Requests that arrive while a routine runs are remembered and taken later, so none is lost. For an interrupt or fault, the return address is the instruction that was current at entry. For a system call, it is the instruction after the trap. Vector slots can be rewritten only from monitor mode. A write attempted from user mode is dropped and turns into a privilege fault.

Top module: `trap_seq`

## Requirements
- R1: After reset the block is in monitor mode (`modeUser`=0), not in service, `redirect` is low, and vector slot i holds i*16.
- R2: Vector slot layout: slot 0 is the privilege fault, slots 1..2 are `faultReq[0..1]`, slot 3 is the system call, and slots 4..7 are `irqReq[0..3]`. A cause is recorded at the clock edge where its request is high. On the following edge, if the block is idle, it enters: `redirect` is high for one cycle, `nextPc` equals the chosen slot's contents, and `causeId` equals the slot number.
- R3: Every entry forces `modeUser` to 0 and sets `inService`.
- R4: While `inService` is high, no further entry occurs and `causeId` holds. A request made meanwhile stays pending and is entered on the edge after the return.
- R5: For a fault or interrupt entry, the saved return address is the `curPc` value at the entry edge.
- R6: For a system call, the saved return address is the `trapPc` sampled with `trapReq`, plus 4.
- R7: When several causes are pending together, the privilege fault wins first, then the other faults, then the system call, then interrupts. Within a class, the lowest index wins.
- R8: A vector write (`vecWe`) in monitor mode replaces slot `vecIdx` with `vecData`. Later entries through that slot use the new value.
- R9: A vector write in user mode leaves the table unchanged and raises a privilege fault (slot 0).
- R10: A return request while in service drives `redirect` high for one cycle with `nextPc` equal to the saved address. It restores the saved mode and clears `inService`.
- R11: `setUserReq` while idle switches `modeUser` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultReq | input | 2 | Fault pulses, one per fault cause |
| trapReq | input | 1 | System call pulse |
| trapPc | input | 16 | Address of the trapping instruction, sampled with trapReq |
| irqReq | input | 4 | External interrupt pulses |
| curPc | input | 16 | Address of the instruction currently being executed |
| retReq | input | 1 | Return-from-service request |
| setUserReq | input | 1 | Request to drop to user mode |
| vecWe | input | 1 | Vector table write strobe |
| vecIdx | input | 3 | Vector slot to write |
| vecData | input | 16 | Routine address to store |
| redirect | output | 1 | One-cycle pulse: core must fetch from nextPc |
| nextPc | output | 16 | Fetch address for the redirect |
| modeUser | output | 1 | Mode bit, 1 = user, 0 = monitor |
| inService | output | 1 | A service routine is active; entries are masked |
| causeId | output | 3 | Slot number of the cause being serviced |

## Verification
The assertions assume that the core issues `retReq` only while a routine is active. They also assume that `setUserReq` is never raised on the same cycle as a return. The directed tasks keep to this: a return is requested only after an entry has been observed, and a mode drop is requested only while idle. Every request is a single-cycle pulse driven on the falling edge, so each pending bit is set by exactly one edge.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic enter;     // take the selected cause this edge
    logic ret;       // return from service this edge
    logic vecWr;     // privileged vector write accepted
    logic fromTrap;  // selected cause is the system call
  } seqStrobe_t;
endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int NF = 2,
  parameter int NI = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NF-1:0] faultReq,
  input  logic          trapReq,
  input  logic [NI-1:0] irqReq,
  input  logic          retReq,
  input  logic          setUserReq,
  input  logic          vecWe,
  output seqStrobe_t    st,
  output logic [IW-1:0] selIdx,
  output logic          redirect,
  output logic          modeUser,
  output logic          inService,
  output logic [IW-1:0] causeId
);
  localparam int TRAP_SLOT = NF + 1;
  localparam int IRQ_BASE  = NF + 2;

  logic          pendPriv, pendTrap, savedMode;
  logic [NF-1:0] pendFault, clrFault;
  logic [NI-1:0] pendIrq, clrIrq;
  logic          found, canEnter, doRet, userWrite;

  // Fixed priority: privilege fault, faults, system call, interrupts.
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    if (pendPriv) begin
      found = 1'b1;
    end else if (|pendFault) begin
      found = 1'b1;
      for (int i = NF - 1; i >= 0; i--)
        if (pendFault[i]) selIdx = IW'(1 + i);
    end else if (pendTrap) begin
      found  = 1'b1;
      selIdx = IW'(TRAP_SLOT);
    end else if (|pendIrq) begin
      found = 1'b1;
      for (int i = NI - 1; i >= 0; i--)
        if (pendIrq[i]) selIdx = IW'(IRQ_BASE + i);
    end
  end

  assign canEnter  = found && !inService;
  assign doRet     = retReq && inService;
  assign userWrite = vecWe && modeUser;

  always_comb begin
    for (int i = 0; i < NF; i++) clrFault[i] = canEnter && (selIdx == IW'(1 + i));
    for (int i = 0; i < NI; i++) clrIrq[i]   = canEnter && (selIdx == IW'(IRQ_BASE + i));
  end

  assign st.enter    = canEnter;
  assign st.ret      = doRet;
  assign st.vecWr    = vecWe && !modeUser;
  assign st.fromTrap = selIdx == IW'(TRAP_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPriv  <= 1'b0;
      pendFault <= '0;
      pendTrap  <= 1'b0;
      pendIrq   <= '0;
      inService <= 1'b0;
      modeUser  <= 1'b0;
      savedMode <= 1'b0;
      redirect  <= 1'b0;
      causeId   <= '0;
    end else begin
      pendPriv  <= (pendPriv && !(canEnter && selIdx == '0)) || userWrite;
      pendFault <= (pendFault & ~clrFault) | faultReq;
      pendTrap  <= (pendTrap && !(canEnter && st.fromTrap)) || trapReq;
      pendIrq   <= (pendIrq & ~clrIrq) | irqReq;
      redirect  <= canEnter || doRet;
      if (canEnter) begin
        inService <= 1'b1;
        savedMode <= modeUser;
        modeUser  <= 1'b0;
        causeId   <= selIdx;
      end else if (doRet) begin
        inService <= 1'b0;
        modeUser  <= savedMode;
      end else if (setUserReq && !inService) begin
        modeUser  <= 1'b1;
      end
    end
  end

  AST_ENTRY_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inService) |-> (!modeUser && redirect)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !retReq) |=> (inService && $stable(causeId))); // R4
  AST_USER_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (vecWe && modeUser) |=> pendPriv); // R9
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && inService) |=> (!inService && redirect && modeUser == $past(savedMode))); // R10
endmodule

// File: rtl/trap_seq_path.sv
module trap_seq_path
  import trap_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NV    = 8,
  parameter int IW    = 3,
  parameter int INSN  = 4,
  parameter int VSTEP = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    st,
  input  logic [IW-1:0] selIdx,
  input  logic [AW-1:0] curPc,
  input  logic          trapReq,
  input  logic [AW-1:0] trapPc,
  input  logic [IW-1:0] vecIdx,
  input  logic [AW-1:0] vecData,
  output logic [AW-1:0] nextPc
);
  logic [AW-1:0] vecTab [NV];
  logic [AW-1:0] epc, trapRet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NV; i++) vecTab[i] <= AW'(i * VSTEP);
      epc     <= '0;
      trapRet <= '0;
      nextPc  <= '0;
    end else begin
      if (st.vecWr && int'(vecIdx) < NV) vecTab[vecIdx] <= vecData;
      if (trapReq) trapRet <= trapPc + AW'(INSN);
      if (st.enter) begin
        epc    <= st.fromTrap ? trapRet : curPc;
        nextPc <= vecTab[selIdx];
      end else if (st.ret) begin
        nextPc <= epc;
      end
    end
  end

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    st.ret |=> (nextPc == $past(epc))); // R10
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NF    = 2,
  parameter int NI    = 4,
  parameter int INSN  = 4,
  parameter int VSTEP = 16,
  localparam int NV   = NF + NI + 2,
  localparam int IW   = $clog2(NV)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NF-1:0] faultReq,
  input  logic          trapReq,
  input  logic [AW-1:0] trapPc,
  input  logic [NI-1:0] irqReq,
  input  logic [AW-1:0] curPc,
  input  logic          retReq,
  input  logic          setUserReq,
  input  logic          vecWe,
  input  logic [IW-1:0] vecIdx,
  input  logic [AW-1:0] vecData,
  output logic          redirect,
  output logic [AW-1:0] nextPc,
  output logic          modeUser,
  output logic          inService,
  output logic [IW-1:0] causeId
);
  seqStrobe_t    st;
  logic [IW-1:0] selIdx;

  trap_seq_ctrl #(.NF(NF), .NI(NI), .IW(IW)) uCtrl (
    .clk(clk), .rstN(rstN), .faultReq(faultReq), .trapReq(trapReq),
    .irqReq(irqReq), .retReq(retReq), .setUserReq(setUserReq), .vecWe(vecWe),
    .st(st), .selIdx(selIdx), .redirect(redirect), .modeUser(modeUser),
    .inService(inService), .causeId(causeId)
  );

  trap_seq_path #(.AW(AW), .NV(NV), .IW(IW), .INSN(INSN), .VSTEP(VSTEP)) uPath (
    .clk(clk), .rstN(rstN), .st(st), .selIdx(selIdx), .curPc(curPc),
    .trapReq(trapReq), .trapPc(trapPc), .vecIdx(vecIdx), .vecData(vecData),
    .nextPc(nextPc)
  );
endmodule

// File: tb/trap_seq_test.sv
module trap_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  faultReq = '0;
  logic        trapReq = 1'b0;
  logic [15:0] trapPc = '0;
  logic [3:0]  irqReq = '0;
  logic [15:0] curPc = 16'h0100;
  logic        retReq = 1'b0;
  logic        setUserReq = 1'b0;
  logic        vecWe = 1'b0;
  logic [2:0]  vecIdx = '0;
  logic [15:0] vecData = '0;
  logic        redirect, modeUser, inService;
  logic [15:0] nextPc;
  logic [2:0]  causeId;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  trap_seq uut (
    .clk(clk), .rstN(rstN), .faultReq(faultReq), .trapReq(trapReq), .trapPc(trapPc),
    .irqReq(irqReq), .curPc(curPc), .retReq(retReq), .setUserReq(setUserReq),
    .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData), .redirect(redirect),
    .nextPc(nextPc), .modeUser(modeUser), .inService(inService), .causeId(causeId)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Request pulsed on one negedge; entry visible two edges later.
  task automatic expectEntry(input string req, input logic [15:0] pc, input logic [2:0] cid);
    check({req, " redirect"}, redirect, 1);
    check({req, " nextPc"}, nextPc, pc);
    check({req, " causeId"}, causeId, cid);
    check({req, " mode"}, modeUser, 0);
    check({req, " inService"}, inService, 1);
  endtask

  task automatic doReturn(input string req, input logic [15:0] pc, input logic mode);
    retReq = 1'b1; tick(); retReq = 1'b0;
    check({req, " ret redirect"}, redirect, 1);
    check({req, " ret nextPc"}, nextPc, pc);
    check({req, " ret mode"}, modeUser, mode);
    check({req, " ret inService"}, inService, 0);
  endtask

  task automatic testReset();
    check("R1 redirect", redirect, 0);
    check("R1 mode", modeUser, 0);
    check("R1 inService", inService, 0);
  endtask

  task automatic testIrq();
    irqReq = 4'b0100; tick(); irqReq = '0; tick();
    expectEntry("R2 R3 R5 irq2", 16'd96, 3'd6);
    tick();
    check("R2 one-cycle redirect", redirect, 0);
    doReturn("R10 R5 irq2", 16'h0100, 1'b0);
  endtask

  task automatic testMask();
    irqReq = 4'b0001; tick(); irqReq = '0; tick();
    expectEntry("R4 irq0", 16'd64, 3'd4);
    irqReq = 4'b0010; tick(); irqReq = '0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R4 masked no redirect", redirect, 0);
      check("R4 cause held", causeId, 4);
    end
    doReturn("R4 irq0", 16'h0100, 1'b0);
    tick();
    expectEntry("R4 pending irq1", 16'd80, 3'd5);
    doReturn("R4 irq1", 16'h0100, 1'b0);
  endtask

  task automatic testPriority();
    setUserReq = 1'b1; tick(); setUserReq = 1'b0;
    check("R11 user mode", modeUser, 1);
    curPc = 16'h0200; trapPc = 16'h0300;
    faultReq = 2'b10; trapReq = 1'b1; irqReq = 4'b0001; tick();
    faultReq = '0; trapReq = 1'b0; irqReq = '0; tick();
    expectEntry("R7 fault first", 16'd32, 3'd2);
    doReturn("R7 R10 fault", 16'h0200, 1'b1);
    tick();
    expectEntry("R7 trap second", 16'd48, 3'd3);
    doReturn("R6 trap return", 16'h0304, 1'b1);
    tick();
    expectEntry("R7 irq last", 16'd64, 3'd4);
    doReturn("R7 irq", 16'h0200, 1'b1);
  endtask

  task automatic testVecWrite();
    // Now in user mode: write must be dropped and fault.
    vecWe = 1'b1; vecIdx = 3'd5; vecData = 16'h5555; tick(); vecWe = 1'b0; tick();
    expectEntry("R9 privilege fault", 16'd0, 3'd0);
    doReturn("R9 priv", 16'h0200, 1'b1);
    irqReq = 4'b0010; tick(); irqReq = '0; tick();
    expectEntry("R9 slot unchanged", 16'd80, 3'd5);
    // In monitor mode (in service) the write takes effect.
    vecWe = 1'b1; vecIdx = 3'd5; vecData = 16'h1234; tick(); vecWe = 1'b0;
    check("R8 no fault in monitor", redirect, 0);
    doReturn("R8 ret", 16'h0200, 1'b1);
    irqReq = 4'b0010; tick(); irqReq = '0; tick();
    expectEntry("R8 new slot value", 16'h1234, 3'd5);
    doReturn("R8 ret2", 16'h0200, 1'b1);
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testIrq();
    testMask();
    testPriority();
    testVecWrite();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule